// File: doc/BRIEF.md
# Receive Byte Queue with Line-Break Insertion

This block holds received bytes for one serial channel between the deserializer and the host. The deserializer offers a byte with a one-cycle strobe. The host takes the oldest byte by strobing a pop while it reads the head output. Two status levels tell the host the state of the queue: one says at least one byte is waiting, the other says the queue is full. A flow-control output tells the deserializer whether it may send another byte.

When a line break is detected, a strobe enqueues a zero byte and latches a break-change flag. The flag stays set until the host acknowledges it. A push that arrives while the queue is full is never dropped. It replaces the newest entry, so the most recent event always reaches the host.

A receiver-reset strobe empties the queue. When a pop and a push fall in the same cycle, the pop is applied first and the push second.

Top module: `rx_break_fifo`

## Requirements
- R1: After reset the queue is empty, `data_ready`, `queue_full` and `break_seen` are low, and `head_data` reads 0.
- R2: Accepted bytes are returned on `head_data` in arrival order. The head is valid in any cycle when `data_ready` is high, and `pop` advances it at the next clock edge.
- R3: A push or a break sets `data_ready` from the following cycle. `data_ready` falls only when the count reaches zero.
- R4: `queue_full` rises once four bytes are held. A pop with no push in the same cycle clears it from the following cycle.
- R5: A push while four bytes are held overwrites the newest entry. The count stays at four and the three older bytes are kept.
- R6: A `line_break` strobe enqueues the byte 0x00 and sets `break_seen`. If `line_break` and `push` coincide, only the zero byte is enqueued.
- R7: `break_seen` stays high until `break_ack` is strobed. A `line_break` in the same cycle as `break_ack` keeps the flag set.
- R8: A pop while the queue is empty has no effect, and `head_data` reads 0 while empty.
- R9: `accept_ok` is high exactly when `rx_enable` is high and the queue is not full.
- R10: A pop and a push in the same cycle remove the oldest byte first, then append. On a full queue this leaves four bytes and no overwrite.
- R11: `rx_clear` empties the queue and drops `data_ready` and `queue_full` at the next edge. It overrides any push, break or pop in the same cycle and leaves `break_seen` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receiver enabled level |
| push | input | 1 | Byte strobe from the deserializer |
| push_data | input | 8 | Byte to enqueue |
| line_break | input | 1 | Break-detected strobe |
| pop | input | 1 | Host takes the head byte |
| rx_clear | input | 1 | Receiver reset strobe |
| break_ack | input | 1 | Clears the break-change flag |
| head_data | output | 8 | Oldest byte, 0 when empty |
| data_ready | output | 1 | At least one byte held |
| queue_full | output | 1 | Four bytes held |
| accept_ok | output | 1 | Deserializer may push |
| break_seen | output | 1 | Break-change flag |

## Verification
Every strobe takes effect at the clock edge that samples it. The flags, the head byte and the break flag therefore change exactly one cycle after the stimulus. `accept_ok` is the only output that also follows `rx_enable` in the same cycle. The bench drives inputs on the falling edge and samples all outputs one nanosecond later. It updates its queue model right after each rising edge, so each comparison sees the state left by the previous cycle's strobes. That state is combined with the current enable level.

// File: rtl/rxq_pkg.sv
// Package: shared constants and types for the receive byte queue.
// Assumes: depth is small (a handful of entries); byte width is 8.
package rxq_pkg;
    localparam int unsigned RXQ_DEPTH  = 4;
    localparam int unsigned RXQ_DATA_W = 8;

    // How the write side of the queue behaves in a given cycle.
    typedef enum logic [1:0] {
        WR_IDLE    = 2'd0,
        WR_APPEND  = 2'd1,
        WR_REPLACE = 2'd2
    } rxq_wr_kind_e;
endpackage

// File: rtl/rxq_ctrl.sv
// Module: pointer and occupancy control for the receive queue.
// Applies clear, then pop, then push/break each cycle. A push into a full
// queue rewrites the newest slot. Assumes DEPTH >= 2.
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH  = RXQ_DEPTH,
    parameter int unsigned DATA_W = RXQ_DATA_W,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              line_break,
    input  logic              pop,
    input  logic              rx_clear,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [PTR_W-1:0]  rd_addr,
    output logic [CNT_W-1:0]  count
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_mid;
    logic             pop_ok, put;
    rxq_wr_kind_e     kind;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_LAST : p - 1'b1;
    endfunction

    // Decide the pop effect first, then classify the write.
    always_comb begin
        pop_ok  = pop && (cnt_q != '0);
        cnt_mid = cnt_q - CNT_W'(pop_ok);
        put     = push || line_break;
        if (!put)                   kind = WR_IDLE;
        else if (cnt_mid == CNT_FULL) kind = WR_REPLACE;
        else                        kind = WR_APPEND;
    end

    // Next pointer and count values, with clear taking priority.
    always_comb begin
        rptr_d  = pop_ok ? ptr_inc(rptr_q) : rptr_q;
        wptr_d  = wptr_q;
        cnt_d   = cnt_mid;
        wr_addr = wptr_q;
        unique case (kind)
            WR_APPEND: begin
                wptr_d = ptr_inc(wptr_q);
                cnt_d  = cnt_mid + 1'b1;
            end
            WR_REPLACE: wr_addr = ptr_dec(wptr_q);
            default: ;
        endcase
        if (rx_clear) begin
            rptr_d = '0;
            wptr_d = '0;
            cnt_d  = '0;
        end
    end

    // Write strobe and byte; a break always carries zero.
    always_comb begin
        wr_en   = (kind != WR_IDLE) && !rx_clear;
        wr_data = line_break ? '0 : push_data;
    end

    // State registers for pointers and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q <= '0;
            wptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            rptr_q <= rptr_d;
            wptr_q <= wptr_d;
            cnt_q  <= cnt_d;
        end
    end

    assign rd_addr = rptr_q;
    assign count   = cnt_q;

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);

    p_replace_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_FULL && push && !pop && !rx_clear) |=> (cnt_q == CNT_FULL));

    p_pop_then_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_FULL && pop && push && !rx_clear) |=> (cnt_q == CNT_FULL));

    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && pop && !push && !line_break && !rx_clear)
            |=> (cnt_q == '0 && $stable(rptr_q)));
endmodule

// File: rtl/rxq_store.sv
// Module: byte storage for the receive queue, one write port and one
// asynchronous read port. Assumes the write address is always in range.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH  = RXQ_DEPTH,
    parameter int unsigned DATA_W = RXQ_DATA_W,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // One holding register per entry, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && (wr_addr == PTR_W'(g)))
                slot_q[g] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_addr];
endmodule

// File: rtl/rxq_flags.sv
// Module: status levels, flow-control ready and the break-change flag.
// Assumes count never exceeds DEPTH.
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH  = RXQ_DEPTH,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             rx_enable,
    input  logic             line_break,
    input  logic             break_ack,
    output logic             data_ready,
    output logic             queue_full,
    output logic             accept_ok,
    output logic             break_seen
);
    logic brk_q;

    // Occupancy levels and the deserializer ready.
    always_comb begin
        data_ready = (count != '0);
        queue_full = (count == CNT_W'(DEPTH));
        accept_ok  = rx_enable && !queue_full;
    end

    // Break flag: set by a break, cleared by acknowledge, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)          brk_q <= 1'b0;
        else if (line_break) brk_q <= 1'b1;
        else if (break_ack)  brk_q <= 1'b0;
    end

    assign break_seen = brk_q;

    p_break_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_break |=> break_seen);

    p_break_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (break_seen && !break_ack) |=> break_seen);

    p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        queue_full |-> !accept_ok);
endmodule

// File: rtl/rx_break_fifo.sv
// Module: top of the receive byte queue with line-break insertion.
// Ties control, storage and flags together; the head byte is gated to zero
// while the queue is empty. Assumes one-cycle strobes on all event inputs.
module rx_break_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH  = RXQ_DEPTH,
    parameter int unsigned DATA_W = RXQ_DATA_W,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              line_break,
    input  logic              pop,
    input  logic              rx_clear,
    input  logic              break_ack,
    output logic [DATA_W-1:0] head_data,
    output logic              data_ready,
    output logic              queue_full,
    output logic              accept_ok,
    output logic              break_seen
);
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic [CNT_W-1:0]  count;

    rxq_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .line_break(line_break), .pop(pop), .rx_clear(rx_clear),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .count(count)
    );

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    rxq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .count(count), .rx_enable(rx_enable),
        .line_break(line_break), .break_ack(break_ack),
        .data_ready(data_ready), .queue_full(queue_full),
        .accept_ok(accept_ok), .break_seen(break_seen)
    );

    // Head byte presented to the host, zero when nothing is held.
    always_comb head_data = data_ready ? rd_data : '0;

    p_full_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        queue_full |-> data_ready);

    p_pop_clears_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !line_break && !rx_clear) |=> !queue_full);

    p_push_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((push || line_break) && !rx_clear) |=> data_ready);

    p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clear |=> (!data_ready && !queue_full));
endmodule

// File: tb/test_rx_break_fifo.sv
module test_rx_break_fifo;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_enable, push, line_break, pop, rx_clear, break_ack;
    logic [7:0] push_data;
    logic [7:0] head_data;
    logic       data_ready, queue_full, accept_ok, break_seen;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  run_done = 0;

    logic [7:0] mq[$];
    bit         m_brk = 0;

    always #10 clk = ~clk;

    rx_break_fifo i_rx_break_fifo (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .push(push),
        .push_data(push_data), .line_break(line_break), .pop(pop),
        .rx_clear(rx_clear), .break_ack(break_ack), .head_data(head_data),
        .data_ready(data_ready), .queue_full(queue_full),
        .accept_ok(accept_ok), .break_seen(break_seen)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [7:0] eh;
        eh = (mq.size() > 0) ? mq[0] : 8'h00;
        check(head_data == eh, tag, "head_data", head_data, eh);
        check(data_ready == (mq.size() > 0), tag, "data_ready", data_ready, mq.size() > 0);
        check(queue_full == (mq.size() == 4), tag, "queue_full", queue_full, mq.size() == 4);
        check(accept_ok == (rx_enable && mq.size() != 4), tag, "accept_ok",
              accept_ok, rx_enable && mq.size() != 4);
        check(break_seen == m_brk, tag, "break_seen", break_seen, m_brk);
    endtask

    // One cycle: drive at the falling edge, compare, clock, update model.
    task automatic cyc(input bit p, input logic [7:0] d, input bit b, input bit po,
                       input bit c, input bit a, input bit e, input string tag);
        logic [7:0] byt;
        push = p; push_data = d; line_break = b; pop = po;
        rx_clear = c; break_ack = a; rx_enable = e;
        #1;
        compare_all(tag);
        @(posedge clk);
        if (c) mq.delete();
        else begin
            if (po && mq.size() > 0) void'(mq.pop_front());
            if (p || b) begin
                byt = b ? 8'h00 : d;
                if (mq.size() == 4) mq[3] = byt;
                else mq.push_back(byt);
            end
        end
        if (b) m_brk = 1;
        else if (a) m_brk = 0;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 0, 0, 1, tag);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!run_done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        rst_n = 0; rx_enable = 0; push = 0; push_data = 0; line_break = 0;
        pop = 0; rx_clear = 0; break_ack = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(head_data == 8'h00, "R1", "head_data", head_data, 0);
        check(!data_ready && !queue_full && !break_seen, "R1", "flags",
              {data_ready, queue_full, break_seen}, 0);
        rst_n = 1;
        idle(2, "R1");

        // R2: order of three bytes, R3 ready on push and fall at zero
        cyc(1, 8'hA1, 0, 0, 0, 0, 1, "R3");
        cyc(1, 8'hB2, 0, 0, 0, 0, 1, "R2");
        cyc(1, 8'hC3, 0, 0, 0, 0, 1, "R2");
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 0, 1, 0, 0, 1, "R2");
        idle(1, "R3");

        // R4 fill to four, R9 ready drops, pop clears full
        for (int i = 0; i < 4; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 0, 0, 1, "R4");
        cyc(0, 8'h00, 0, 0, 0, 0, 0, "R9");
        cyc(0, 8'h00, 0, 1, 0, 0, 1, "R4");
        idle(1, "R9");

        // R5 overwrite newest when full, then drain
        cyc(1, 8'h55, 0, 0, 0, 0, 1, "R5");
        cyc(1, 8'h66, 0, 0, 0, 0, 1, "R5");
        cyc(1, 8'h77, 0, 0, 0, 0, 1, "R5");
        for (int i = 0; i < 5; i++) cyc(0, 8'h00, 0, 1, 0, 0, 1, "R5");

        // R8 pop on empty
        cyc(0, 8'h00, 0, 1, 0, 0, 1, "R8");
        idle(1, "R8");

        // R6 break pushes zero and beats a coinciding byte
        cyc(1, 8'h31, 0, 0, 0, 0, 1, "R6");
        cyc(0, 8'h00, 1, 0, 0, 0, 1, "R6");
        cyc(1, 8'hEE, 1, 0, 0, 0, 1, "R6");
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 1, 0, 0, 1, "R6");

        // R7 hold until ack; break wins over ack
        idle(2, "R7");
        cyc(0, 8'h00, 0, 0, 0, 1, 1, "R7");
        cyc(0, 8'h00, 1, 0, 0, 1, 1, "R7");
        cyc(0, 8'h00, 0, 1, 0, 1, 1, "R7");
        idle(1, "R7");

        // R6 break into a full queue replaces the newest
        for (int i = 0; i < 4; i++) cyc(1, 8'h40 + 8'(i), 0, 0, 0, 0, 1, "R6");
        cyc(0, 8'h00, 1, 0, 0, 0, 1, "R6");
        // R10 pop and push together on full
        cyc(1, 8'h99, 0, 1, 0, 0, 1, "R10");
        // R10 pop and push together on empty afterwards
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 0, 1, 0, 0, 1, "R10");
        cyc(1, 8'h5A, 0, 1, 0, 0, 1, "R10");
        idle(1, "R10");

        // R11 clear overrides push and pop, leaves break flag
        cyc(1, 8'h01, 1, 0, 0, 0, 1, "R11");
        cyc(1, 8'h02, 0, 0, 0, 0, 1, "R11");
        cyc(1, 8'h03, 1, 1, 1, 0, 1, "R11");
        idle(2, "R11");

        // Random mix compared each cycle
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            cyc(r < 45, 8'($urandom), (r % 17) == 0, $urandom_range(0, 2) == 0,
                r == 98, (r % 11) == 0, $urandom_range(0, 5) != 0, "R2");
        end
        idle(2, "R2");

        run_done = 1;
        finish_run();
    end
endmodule